// File: doc/BRIEF.md
# Multi-Stream Wall Clock Advance Gate

This block owns a 64-bit wall clock value that several audio streams share. A requester proposes a new clock time with a one-cycle pulse. The block keeps the clock from running ahead of any stream. A normal (non-forced) proposal is applied only when every enabled stream says its current period has gone past the proposed time. When it is applied, the value stored is raised to the largest absolute elapsed time among the enabled streams, if that is larger than the proposal. A forced proposal bypasses the stream checks and writes the proposed value as it is.

Each request gets one response, one cycle after the request pulse. The response says whether the clock now holds exactly the proposed value, or whether the update was delayed or adjusted. The block also flags a normal update that would move the clock backwards. It raises a warning when normal updates keep writing the value the clock already holds. Stream period tracking happens outside this block; per-stream flags and elapsed times arrive on ports.

Top module: `wclk_gate`

## Requirements
- R1: After a clock edge with `rst_n` low, `wclk` is 0, `rsp_valid`, `rsp_ok`, `bkwd_err` and `stale_warn` are 0, and the stale count is cleared.
- R2: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` was high, and low otherwise.
- R3: A non-forced request is not applied when any enabled stream has its `strm_passed` bit low; `wclk` keeps its previous value.
- R4: A stream whose `strm_en` bit is 0 neither blocks a request nor contributes its elapsed time to the stored value.
- R5: An applied non-forced request stores the maximum of `req_value` and the elapsed times of all enabled streams. Stream i's elapsed time is `strm_elapsed[64*i +: 64]`.
- R6: A forced request (`req_force`=1) stores `req_value` unchanged, whatever the stream flags and elapsed times are.
- R7: In the response cycle, `rsp_ok` is 1 exactly when `wclk` then equals the requested value. Otherwise the update counts as delayed.
- R8: `bkwd_err` pulses in the response cycle of an applied non-forced request whose stored value is lower than the previous clock value. The value is still written.
- R9: Each applied non-forced request that stores the value `wclk` already holds raises the stale count by one. `stale_warn` is 1 while the count exceeds 3, so it goes high on the fourth such update in a row. Any applied request that stores a different value clears the count and the warning.
- R10: With no request, `wclk` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle update request |
| req_value | input | 64 | Proposed clock value |
| req_force | input | 1 | Bypass stream checks and maximum |
| strm_en | input | N_STREAMS | Per-stream enable mask |
| strm_passed | input | N_STREAMS | Stream period has passed the proposed time |
| strm_elapsed | input | 64*N_STREAMS | Per-stream absolute elapsed time, packed |
| wclk | output | 64 | Current wall clock value |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_ok | output | 1 | Clock equals the requested value |
| bkwd_err | output | 1 | Non-forced update moved the clock backwards |
| stale_warn | output | 1 | Repeated same-value updates beyond the limit |

## Verification
Requests are tried with all streams passed and the proposal above every elapsed time, which shows a plain write. They are also tried with an elapsed time above the proposal, which separates the maximum path from a plain write and makes `rsp_ok` drop. One enabled stream that has not passed shows the gate holding the clock. The same condition on a disabled stream, carrying a huge elapsed time, shows that the mask removes the stream both from the gate and from the maximum. Forced lower values, a backward non-forced write and a run of four identical updates followed by a fresh value cover the error flag and the warning threshold.

// File: rtl/wclk_pkg.sv
// Shared width and type for the wall clock gate.
package wclk_pkg;
    localparam int WCLK_W = 64;
    typedef logic [WCLK_W-1:0] wclk_t;
endpackage

// File: rtl/wclk_stream_reduce.sv
// Combines the per-stream inputs into one gate bit and one candidate value.
// Assumes: elapsed times are packed, stream i at [W*i +: W]; disabled streams are ignored.
module wclk_stream_reduce
    import wclk_pkg::*;
#(
    parameter int N_STREAMS = 3
) (
    input  logic [N_STREAMS-1:0]        en,
    input  logic [N_STREAMS-1:0]        passed,
    input  logic [WCLK_W*N_STREAMS-1:0] elapsed,
    input  wclk_t                       base_value,
    output logic                        all_passed,
    output wclk_t                       max_value
);
    wclk_t chain [0:N_STREAMS];

    // Gate: every enabled stream must have passed.
    assign all_passed = &(passed | ~en);

    assign chain[0] = base_value;

    // Maximum chain: each enabled stream may raise the running value.
    for (genvar i = 0; i < N_STREAMS; i++) begin : g_max
        wclk_t el;
        assign el          = elapsed[WCLK_W*i +: WCLK_W];
        assign chain[i+1]  = (en[i] && (el > chain[i])) ? el : chain[i];
    end

    assign max_value = chain[N_STREAMS];
endmodule

// File: rtl/wclk_stale_tracker.sv
// Counts consecutive non-forced updates that rewrite the current value.
// Assumes: apply_nf implies apply_any; same_value compares against the value before the write.
module wclk_stale_tracker #(
    parameter int STALE_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic apply_any,
    input  logic apply_nf,
    input  logic same_value,
    output logic stale_warn
);
    localparam int CNT_MAX = STALE_LIMIT + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count register: saturating increment on stale repeat, clear on a new value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (apply_nf && same_value) begin
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        end else if (apply_any && !same_value) begin
            cnt_q <= '0;
        end
    end

    // Warning level: count beyond the limit.
    assign stale_warn = (cnt_q > CNT_W'(STALE_LIMIT));

    assert_warn_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_any && !same_value) |=> !stale_warn);
    assert_warn_holds_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_any) |=> $stable(stale_warn));
    assert_warn_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stale_warn && !(apply_nf && same_value)) |=> !stale_warn);
endmodule

// File: rtl/wclk_gate.sv
// Wall clock register that only advances when all enabled streams agree.
// Assumes: request inputs valid only in the req_valid cycle; response one cycle later.
module wclk_gate
    import wclk_pkg::*;
#(
    parameter int N_STREAMS   = 3,
    parameter int STALE_LIMIT = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [63:0]                 req_value,
    input  logic                        req_force,
    input  logic [N_STREAMS-1:0]        strm_en,
    input  logic [N_STREAMS-1:0]        strm_passed,
    input  logic [64*N_STREAMS-1:0]     strm_elapsed,
    output logic [63:0]                 wclk,
    output logic                        rsp_valid,
    output logic                        rsp_ok,
    output logic                        bkwd_err,
    output logic                        stale_warn
);
    wclk_t wclk_q;
    wclk_t max_value;
    wclk_t cand;
    logic  all_passed;
    logic  gate;
    logic  apply_any;
    logic  apply_nf;
    logic  same_value;

    wclk_stream_reduce #(.N_STREAMS(N_STREAMS)) u_reduce (
        .en         (strm_en),
        .passed     (strm_passed),
        .elapsed    (strm_elapsed),
        .base_value (req_value),
        .all_passed (all_passed),
        .max_value  (max_value)
    );

    // Decision: forced requests bypass gate and maximum.
    always_comb begin
        gate       = req_force || all_passed;
        cand       = req_force ? req_value : max_value;
        apply_any  = req_valid && gate;
        apply_nf   = apply_any && !req_force;
        same_value = (cand == wclk_q);
    end

    // Clock register and response flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            bkwd_err  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= req_valid && (gate ? (cand == req_value) : (wclk_q == req_value));
            bkwd_err  <= apply_nf && (cand < wclk_q);
            if (apply_any) wclk_q <= cand;
        end
    end

    wclk_stale_tracker #(.STALE_LIMIT(STALE_LIMIT)) u_stale (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply_any  (apply_any),
        .apply_nf   (apply_nf),
        .same_value (same_value),
        .stale_warn (stale_warn)
    );

    assign wclk = wclk_q;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(wclk));
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_force && !(&(strm_passed | ~strm_en))) |=> $stable(wclk));
    assert_force_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_force) |=> (wclk == $past(req_value)));
    assert_applied_not_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_force && (&(strm_passed | ~strm_en))) |=> (wclk >= $past(req_value)));
    assert_ok_means_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (wclk == $past(req_value)));
    assert_err_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bkwd_err |-> rsp_valid);
endmodule

// File: tb/tb_wclk_gate.sv
module tb_wclk_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [63:0]       req_value;
    logic              req_force;
    logic [NS-1:0]     strm_en;
    logic [NS-1:0]     strm_passed;
    logic [64*NS-1:0]  strm_elapsed;
    logic [63:0]       wclk;
    logic              rsp_valid, rsp_ok, bkwd_err, stale_warn;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] exp_wclk = '0;
    int          exp_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wclk_gate #(.N_STREAMS(NS), .STALE_LIMIT(3)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
        .req_force(req_force), .strm_en(strm_en), .strm_passed(strm_passed),
        .strm_elapsed(strm_elapsed), .wclk(wclk), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .bkwd_err(bkwd_err), .stale_warn(stale_warn)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One request with the model applied from the requirements, then all outputs checked.
    task automatic do_req(string tag, logic [63:0] val, logic frc, logic [NS-1:0] en,
                          logic [NS-1:0] ps, logic [63:0] e0, logic [63:0] e1, logic [63:0] e2);
        logic [63:0] el [NS];
        logic        gate;
        logic [63:0] cand;
        logic        eok, eerr;
        el[0] = e0; el[1] = e1; el[2] = e2;
        gate = frc;
        if (!frc) begin
            gate = 1'b1;
            for (int i = 0; i < NS; i++) if (en[i] && !ps[i]) gate = 1'b0;
        end
        cand = val;
        if (!frc) for (int i = 0; i < NS; i++) if (en[i] && el[i] > cand) cand = el[i];
        eerr = gate && !frc && (cand < exp_wclk);
        if (gate) begin
            if (cand == exp_wclk) begin
                if (!frc && exp_cnt < 4) exp_cnt++;
            end else exp_cnt = 0;
            exp_wclk = cand;
        end
        eok = (exp_wclk == val);
        @(negedge clk);
        req_valid = 1'b1; req_value = val; req_force = frc;
        strm_en = en; strm_passed = ps; strm_elapsed = {e2, e1, e0};
        @(negedge clk);
        req_valid = 1'b0; req_value = '1; req_force = 1'b0; strm_passed = '0;
        strm_elapsed = '1;
        check(tag, "wclk", wclk, exp_wclk);
        check("R2", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
        check("R7", "rsp_ok", {63'd0, rsp_ok}, {63'd0, eok});
        check("R8", "bkwd_err", {63'd0, bkwd_err}, {63'd0, eerr});
        check("R9", "stale_warn", {63'd0, stale_warn}, {63'd0, exp_cnt > 3});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "wclk", wclk, 64'd0);
        check("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1", "stale_warn", {63'd0, stale_warn}, 64'd0);
        check("R1", "bkwd_err", {63'd0, bkwd_err}, 64'd0);
    endtask

    task automatic t_plain_write();
        do_req("R5", 64'd1000, 1'b0, 3'b111, 3'b111, 64'd900, 64'd950, 64'd10);
    endtask

    task automatic t_max_raise();
        do_req("R5", 64'd2000, 1'b0, 3'b111, 3'b111, 64'd2100, 64'd2500, 64'd2050);
        check("R5", "raised value", wclk, 64'd2500);
    endtask

    task automatic t_gate_block();
        do_req("R3", 64'd3000, 1'b0, 3'b111, 3'b101, 64'd3100, 64'd3200, 64'd3300);
        check("R3", "held", wclk, 64'd2500);
    endtask

    task automatic t_mask();
        do_req("R4", 64'd4000, 1'b0, 3'b011, 3'b011, 64'd10, 64'd20, 64'hFFFF_FFFF_0000_0000);
        check("R4", "masked stream ignored", wclk, 64'd4000);
    endtask

    task automatic t_force();
        do_req("R6", 64'd500, 1'b1, 3'b111, 3'b000, 64'd9000, 64'd9000, 64'd9000);
        check("R6", "forced value", wclk, 64'd500);
    endtask

    task automatic t_backward();
        do_req("R6", 64'd6000, 1'b1, 3'b000, 3'b000, 64'd0, 64'd0, 64'd0);
        do_req("R8", 64'd5000, 1'b0, 3'b001, 3'b001, 64'd5500, 64'd0, 64'd0);
        check("R8", "backward written", wclk, 64'd5500);
    endtask

    task automatic t_stale();
        for (int k = 0; k < 4; k++)
            do_req("R9", 64'd5500, 1'b0, 3'b111, 3'b111, 64'd1, 64'd2, 64'd3);
        check("R9", "warn after fourth", {63'd0, stale_warn}, 64'd1);
        do_req("R9", 64'd7000, 1'b0, 3'b111, 3'b111, 64'd1, 64'd2, 64'd3);
        check("R9", "warn cleared", {63'd0, stale_warn}, 64'd0);
    endtask

    task automatic t_idle();
        repeat (5) @(negedge clk);
        check("R10", "idle hold", wclk, 64'd7000);
        check("R2", "no rsp idle", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_value = '0; req_force = 1'b0;
        strm_en = '0; strm_passed = '0; strm_elapsed = '0;
        t_reset();
        t_plain_write();
        t_max_raise();
        t_gate_block();
        t_mask();
        t_force();
        t_backward();
        t_stale();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule